// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small accumulator processor. It steps through a fixed register-transfer sequence for every instruction. It keeps five architectural registers: a program counter, a memory address register, a memory buffer register, an instruction register and an accumulator. Each 16-bit instruction word holds a 4-bit operation code in bits [15:12] and a 12-bit operand in bits [11:0]. The operand is either a memory address or a device number.

The core drives one single-port word-addressed memory. The memory returns read data one cycle after it sees an address. The core also drives a simple device port. On that port, the operand selects a device and single-cycle read and write strobes move one word.

Five operations are supported: load, add, store, device input and device output. Any other code stops the core for good until the next reset. A synchronous reset loads the program counter from the `start_addr` input. From there, execution runs through consecutive words.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the core loads the program counter from `start_addr` and clears the accumulator and the address, buffer and instruction registers. `halted`, `mem_we`, `io_rd` and `io_wr` are low after reset. In the second cycle after reset, `mem_addr` equals `start_addr`.
- R2: Fetch takes four cycles. In cycle 1 the program counter is copied to the address register. In cycle 2 the memory read is issued and the program counter increments. In cycle 3 the returned word enters the buffer register. In cycle 4 the buffer register is copied to the instruction register. Instructions run from consecutive addresses.
- R3: The operation code is bits [15:12] of the word. The address or device number is bits [11:0].
- R4: Code 1 (load) puts the memory word at the operand address into the accumulator. It takes 8 cycles including fetch.
- R5: Code 5 (add) adds the memory word at the operand address to the accumulator, modulo 2^16. It takes 8 cycles.
- R6: Code 2 (store) writes the accumulator to the operand address. `mem_we` is high for exactly one cycle, in the 7th and last cycle of the instruction.
- R7: Code 3 (input) raises `io_rd` for one cycle, the 5th and last, with `io_dev` equal to the operand. The accumulator takes `io_rdata` from that cycle.
- R8: Code 7 (output) raises `io_wr` for one cycle, the 5th and last. In that cycle `io_dev` equals the operand and `io_wdata` equals the accumulator. The accumulator is left unchanged.
- R9: Codes 0, 4, 6 and 8 to 15 set `halted` in the cycle after their fetch ends. From then until reset, the accumulator is frozen and no strobe is raised.
- R10: At most one of `mem_we`, `io_rd` and `io_wr` is high in any cycle.
- R11: The program counter wraps from 0xFFF to 0x000, and execution continues there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_addr | input | 12 | Program counter value loaded at reset |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Memory read data, one cycle after address |
| io_dev | output | 12 | Selected device number |
| io_wdata | output | 16 | Data to the device |
| io_rd | output | 1 | Single-cycle device read strobe |
| io_wr | output | 1 | Single-cycle device write strobe |
| io_rdata | input | 16 | Data from the selected device |
| halted | output | 1 | Core stopped on an undefined code |
| acc_out | output | 16 | Accumulator value |

## Verification
The bench runs load, add and store over an 8-by-8 grid of operands that includes 0x7FFF, 0x8000 and 0xFFFF. A core that kept a carry bit, or that mistimed the buffer register against the one-cycle read latency, would store wrong sums. Sixteen device numbers, up to 0xFFF, check that input and output route the full operand field; a core that decoded only part of the field would hit the wrong device. Every undefined code is tried after a load, and the bench expects the core to halt at exactly cycle 12, with the accumulator frozen and no later strobe. A core that treated one of these codes as a valid operation would write memory or a device. A program placed across address 0xFFF checks the counter wrap, since a core whose counter did not wrap would fetch from the wrong place.

// File: rtl/acc_core.sv
module acc_core #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] io_dev,
  output logic [DW-1:0] io_wdata,
  output logic          io_rd,
  output logic          io_wr,
  input  logic [DW-1:0] io_rdata,
  output logic          halted,
  output logic [DW-1:0] acc_out
);
  localparam int OW = DW - AW;
  localparam logic [OW-1:0] OP_LD  = OW'(1);
  localparam logic [OW-1:0] OP_ST  = OW'(2);
  localparam logic [OW-1:0] OP_IN  = OW'(3);
  localparam logic [OW-1:0] OP_ADD = OW'(5);
  localparam logic [OW-1:0] OP_OUT = OW'(7);

  typedef enum logic [3:0] {
    F_MAR, F_RD, F_MBR, F_IR,
    X_MAR, X_RD, X_MBR, X_AC,
    X_SMBR, X_WR, X_IN, X_OUT, S_HALT
  } state_t;

  state_t        st;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mbr, ir, ac;

  wire [OW-1:0] op_ir  = ir[DW-1 -: OW];
  wire [OW-1:0] op_mbr = mbr[DW-1 -: OW];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= start_addr;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
      ac  <= '0;
      st  <= F_MAR;
    end else begin
      case (st)
        F_MAR: begin mar <= pc; st <= F_RD; end
        F_RD:  begin pc <= pc + AW'(1); st <= F_MBR; end
        F_MBR: begin mbr <= mem_rdata; st <= F_IR; end
        F_IR: begin
          ir <= mbr;
          case (op_mbr)
            OP_LD, OP_ADD, OP_ST: st <= X_MAR;
            OP_IN:                st <= X_IN;
            OP_OUT:               st <= X_OUT;
            default:              st <= S_HALT;
          endcase
        end
        X_MAR: begin
          mar <= ir[AW-1:0];
          st  <= (op_ir == OP_ST) ? X_SMBR : X_RD;
        end
        X_RD:  st <= X_MBR;
        X_MBR: begin mbr <= mem_rdata; st <= X_AC; end
        X_AC: begin
          ac <= (op_ir == OP_ADD) ? ac + mbr : mbr;
          st <= F_MAR;
        end
        X_SMBR: begin mbr <= ac; st <= X_WR; end
        X_WR:   st <= F_MAR;
        X_IN:   begin ac <= io_rdata; st <= F_MAR; end
        X_OUT:  st <= F_MAR;
        default: st <= S_HALT;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = (st == X_WR);
  assign io_dev    = ir[AW-1:0];
  assign io_wdata  = ac;
  assign io_rd     = (st == X_IN);
  assign io_wr     = (st == X_OUT);
  assign halted    = (st == S_HALT);
  assign acc_out   = ac;
endmodule

module acc_core_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          io_rd,
  input logic          io_wr,
  input logic [DW-1:0] io_rdata,
  input logic [DW-1:0] io_wdata,
  input logic          halted,
  input logic [DW-1:0] acc_out
);
  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!halted && acc_out == '0 && !mem_we && !io_rd && !io_wr));

  p_store_data_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_wdata == acc_out);

  p_we_single_r6: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  p_in_loads_r7: assert property (@(posedge clk) disable iff (rst)
    io_rd |=> (acc_out == $past(io_rdata) && !io_rd));

  p_out_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    io_wr |=> (acc_out == $past(io_wdata) && !io_wr));

  p_halt_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(acc_out) && !mem_we && !io_rd && !io_wr));

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, io_rd, io_wr}));
endmodule

bind acc_core acc_core_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_wdata(mem_wdata),
  .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata), .io_wdata(io_wdata),
  .halted(halted), .acc_out(acc_out)
);

// File: tb/acc_core_tb_top.sv
module acc_core_tb_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] start_addr = '0;
  logic [11:0] mem_addr, io_dev;
  logic [15:0] mem_wdata, io_wdata, io_rdata, acc_out;
  logic [15:0] mem_rdata = '0;
  logic        mem_we, io_rd, io_wr, halted;
  logic [15:0] mem [4096];

  int nchk = 0, nfail = 0;
  int cyc, nout, nwe, nrd, late, halt_cyc, out_cyc, we_cyc, rd_cyc;
  logic [11:0] out_dev, rd_dev, fetch_addr;
  logic [15:0] out_dat;

  always #(PERIOD/2) clk = ~clk;

  acc_core dut_i (
    .clk(clk), .rst(rst), .start_addr(start_addr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata), .io_dev(io_dev), .io_wdata(io_wdata),
    .io_rd(io_rd), .io_wr(io_wr), .io_rdata(io_rdata),
    .halted(halted), .acc_out(acc_out)
  );

  function automatic logic [15:0] dev_val(input logic [11:0] d);
    return {d[3:0], d} ^ 16'hC3A5;
  endfunction

  assign io_rdata = dev_val(io_dev);

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; nout = 0; nwe = 0; nrd = 0; late = 0; halt_cyc = -1;
      out_cyc = -1; we_cyc = -1; rd_cyc = -1;
    end else begin
      if (io_wr) begin nout++; out_dev = io_dev; out_dat = io_wdata; out_cyc = cyc; end
      if (mem_we) begin nwe++; we_cyc = cyc; end
      if (io_rd) begin nrd++; rd_dev = io_dev; rd_cyc = cyc; end
      if (halted && halt_cyc < 0) halt_cyc = cyc;
      else if (halted && (mem_we || io_rd || io_wr)) late++;
      if (cyc == 1) fetch_addr = mem_addr;
      cyc++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int a = 0; a < 4096; a++) mem[a] = 16'hF000;
  endtask

  task automatic put(input logic [11:0] a, input logic [3:0] op, input logic [11:0] f);
    mem[a] = {op, f};
  endtask

  task automatic run(input logic [11:0] sa);
    start_addr = sa;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    for (int i = 0; i < 400 && halt_cyc < 0; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(halt_cyc >= 0, "watchdog", 0, 1);
  endtask

  initial begin
    clear_mem();
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!halted && acc_out == 0, "R1 reset state", {halted, acc_out}, 0);
    chk(!mem_we && !io_rd && !io_wr, "R1 reset strobes", {mem_we, io_rd, io_wr}, 0);
    chk(mem_addr == 0, "R1 reset address reg", mem_addr, 0);

    clear_mem();
    put(12'h300, 4'd1, 12'h940);
    put(12'h301, 4'd5, 12'h941);
    put(12'h302, 4'd7, 12'h006);
    put(12'h303, 4'd2, 12'h942);
    mem[12'h940] = 16'd3;
    mem[12'h941] = 16'd2;
    run(12'h300);
    chk(fetch_addr == 12'h300, "R1 first fetch address", fetch_addr, 12'h300);
    chk(out_cyc == 20, "R4 R5 R8 output cycle", out_cyc, 20);
    chk(out_dat == 16'd5 && out_dev == 12'h006, "R8 output value/device", {out_dev, out_dat}, {12'h006, 16'd5});
    chk(we_cyc == 27, "R6 store cycle", we_cyc, 27);
    chk(mem[12'h942] == 16'd5, "R6 stored word", mem[12'h942], 5);
    chk(halt_cyc == 32, "R2 R9 halt cycle", halt_cyc, 32);
    chk(acc_out == 16'd5, "R4 accumulator", acc_out, 5);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] va, vb, sum;
        logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'h0002, 16'h7FFF,
                                  16'h8000, 16'hFFFE, 16'hFFFF, 16'h1234};
        va = vals[i]; vb = vals[j];
        sum = 16'((32'(va) + 32'(vb)) % 32'h10000);
        clear_mem();
        put(12'h100, 4'd1, 12'h200);
        put(12'h101, 4'd5, 12'h201);
        put(12'h102, 4'd2, 12'h202);
        put(12'h103, 4'd7, 12'h00A);
        mem[12'h200] = va; mem[12'h201] = vb;
        run(12'h100);
        chk(mem[12'h202] == sum, "R5 wrapped sum stored", mem[12'h202], sum);
        chk(out_dat == sum && nout == 1, "R8 sum output", out_dat, sum);
        chk(nwe == 1 && late == 0, "R10 single write", nwe, 1);
      end
    end

    for (int k = 0; k < 16; k++) begin
      logic [11:0] d;
      d = (k == 15) ? 12'hFFF : 12'((k * 273) % 4096);
      clear_mem();
      put(12'h050, 4'd3, d);
      put(12'h051, 4'd7, 12'h001);
      put(12'h052, 4'd2, 12'h060);
      run(12'h050);
      chk(rd_cyc == 4 && nrd == 1, "R7 input strobe cycle", rd_cyc, 4);
      chk(rd_dev == d, "R3 R7 device field", rd_dev, d);
      chk(out_dat == dev_val(d), "R7 input value", out_dat, dev_val(d));
      chk(mem[12'h060] == dev_val(d), "R7 stored input", mem[12'h060], dev_val(d));
      chk(out_cyc == 9, "R8 output cycle", out_cyc, 9);
    end

    for (int op = 0; op < 16; op++) begin
      if (op == 1 || op == 2 || op == 3 || op == 5 || op == 7) continue;
      clear_mem();
      put(12'h400, 4'd1, 12'h410);
      put(12'h401, 4'(op), 12'h123);
      put(12'h402, 4'd7, 12'h005);
      put(12'h403, 4'd2, 12'h411);
      mem[12'h410] = 16'hBEEF;
      mem[12'h411] = 16'h0000;
      run(12'h400);
      chk(halt_cyc == 12, "R9 halt cycle", halt_cyc, 12);
      chk(nout == 0 && nwe == 0 && nrd == 0 && late == 0, "R9 no strobes", {nout, nwe}, 0);
      chk(acc_out == 16'hBEEF && halted, "R9 frozen accumulator", acc_out, 16'hBEEF);
      chk(mem[12'h411] == 16'h0000, "R9 memory untouched", mem[12'h411], 0);
    end

    clear_mem();
    put(12'hFFE, 4'd1, 12'h010);
    put(12'hFFF, 4'd7, 12'h003);
    put(12'h000, 4'd2, 12'h020);
    put(12'h001, 4'hF, 12'h000);
    mem[12'h010] = 16'h4321;
    run(12'hFFE);
    chk(mem[12'h020] == 16'h4321, "R11 store after wrap", mem[12'h020], 16'h4321);
    chk(nout == 1 && out_dev == 12'h003, "R11 output before wrap", nout, 1);
    chk(halt_cyc == 24, "R11 halt cycle", halt_cyc, 24);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule